// File: doc/BRIEF.md
# Indirect Command Bridge to a 32-bit Peripheral Bus

This block gives a host a narrow window onto a 32-bit internal peripheral bus through four 64-bit registers. The host writes a data word, then writes a command word to the control register. That command write starts one bus transfer at once. The command names the direction, a byte count and a 32-bit bus address. While the transfer is outstanding the bridge holds a request toward the bus, and it reports busy. When the bus answers, the bridge records the outcome in a status register.

The host learns that a command has completed by polling the status register. A read command returns its four bytes packed into the status word, with the byte that arrived first in the most significant position. The status register clears itself on the same access that reads it, so each completion is reported to the host once.

Top module: `cmdb_top`

## Requirements
- R1: Only host address bits [4:3] choose the register: 0 is control, 1 is reset, 2 is status, 3 is data. Other address bits are ignored. An access with `h_full` low is ignored completely: it stores nothing, clears nothing and returns zero.
- R2: A full-width control write with byte count 0 to 8, made while idle, raises `b_req` on the next cycle. The request carries `b_addr` = command bits [31:0] and `b_len` = command bits [59:56]. `b_we` is the inverse of command bit 48, where a 1 in bit 48 means read.
- R3: A control write whose byte count (bits [59:56]) is above 8 issues no request and leaves the status register unchanged.
- R4: When a read completes without error, the status becomes bit 11 set (done) with the returned 32-bit word in bits [57:26]. The first byte on the bus is `b_rdata[31:24]`, which lands in status bits [57:50]. All other bits are zero.
- R5: When a read completes with `b_err` high, the status becomes bit 11 set with bits [57:26] all ones and all other bits zero.
- R6: A write command drives `b_wdata` with the data register, first byte in bits [31:24]. On completion the status becomes exactly bit 11, whatever the value of `b_err`.
- R7: A status read returns the current status on `h_rdata` one cycle after the strobe and clears the status to zero. A second status read then returns zero.
- R8: A data write stores `h_wdata[63:32]`. A data read returns the stored word in bits [63:32] and zeros in bits [31:0].
- R9: Control and reset registers read as zero. Writes to the reset and status registers change no state.
- R10: `busy` and `b_req` rise together on command acceptance and fall on the cycle after `b_ack`. While they are high, the request fields stay stable and further control writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_full | input | 1 | High when the access is full 64-bit width |
| h_addr | input | ADDR_W | Host address; bits [4:3] select the register |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data, valid the cycle after a read strobe |
| busy | output | 1 | A bus transfer is outstanding |
| b_req | output | 1 | Bus request, held until acknowledged |
| b_we | output | 1 | Bus direction, 1 = write |
| b_addr | output | 32 | Bus address |
| b_len | output | 4 | Bus byte count |
| b_wdata | output | 32 | Bus write data |
| b_ack | input | 1 | Bus response strobe |
| b_rdata | input | 32 | Bus read data |
| b_err | input | 1 | Bus response error |

## Verification
Read commands are issued to addresses with different bus latencies, so a packing error shows up as a wrong bit field in the status word. Other reads go to an address that the bench peripheral answers with an error; these separate the all-ones fill from the packed data. Write commands go to both good and failing addresses, which shows that the write status ignores the error flag. Byte counts of 0, 8, 9 and 15, control writes during a slow transfer, and partial-width or reserved-register accesses each show whether the bridge wrongly takes an action it must refuse.

// File: rtl/cmdb_pkg.sv
package cmdb_pkg;
  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cmdb_decode.sv
module cmdb_decode
  import cmdb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DW        = 64,
  parameter int BUS_AW    = 32,
  parameter int LEN_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int RD_BIT    = 48,
  parameter int LEN_LSB   = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic              h_re,
  input  logic              h_full,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DW-1:0]     h_wdata,
  input  logic              busy,
  output reg_sel_e          sel,
  output logic              data_wr,
  output logic              stat_rd,
  output logic              rd_acc,
  output logic              cmd_go,
  output logic              cmd_rd,
  output logic [BUS_AW-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len
);
  logic wr_acc, ctl_wr, len_ok;
  logic unused_bits;

  assign sel      = reg_sel_e'(h_addr[4:3]);
  assign wr_acc   = h_we & h_full;
  assign rd_acc   = h_re & h_full;
  assign ctl_wr   = wr_acc & (sel == SEL_CTL);
  assign data_wr  = wr_acc & (sel == SEL_DATA);
  assign stat_rd  = rd_acc & (sel == SEL_STAT);
  assign cmd_len  = h_wdata[LEN_LSB +: LEN_W];
  assign cmd_rd   = h_wdata[RD_BIT];
  assign cmd_addr = h_wdata[BUS_AW-1:0];
  assign len_ok   = (cmd_len <= LEN_W'(MAX_BYTES));
  assign cmd_go   = ctl_wr & len_ok & ~busy;

  assign unused_bits = ^{h_wdata[DW-1:LEN_LSB+LEN_W], h_wdata[LEN_LSB-1:RD_BIT+1],
                         h_wdata[RD_BIT-1:BUS_AW], h_addr[2:0], h_addr[ADDR_W-1:5]};

  // an oversized byte count never launches a transfer
  assert_len_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (h_wdata[LEN_LSB +: LEN_W] > LEN_W'(MAX_BYTES))) |-> !cmd_go);
  // launch only from idle
  assert_go_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !busy);
endmodule

// File: rtl/cmdb_master.sv
module cmdb_master #(
  parameter int BUS_AW = 32,
  parameter int BUS_DW = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_rd,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [BUS_DW-1:0] data_q,
  input  logic              b_ack,
  output logic              b_req,
  output logic              b_we,
  output logic [BUS_AW-1:0] b_addr,
  output logic [LEN_W-1:0]  b_len,
  output logic [BUS_DW-1:0] b_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_rd
);
  logic              req_q, req_d;
  logic              we_q;
  logic [BUS_AW-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [BUS_DW-1:0] wd_q;
  logic              load_en;

  assign load_en = cmd_go;

  always_comb begin
    req_d = req_q;
    if (cmd_go)              req_d = 1'b1;
    else if (req_q && b_ack) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      wd_q   <= '0;
    end else if (load_en) begin
      we_q   <= ~cmd_rd;
      addr_q <= cmd_addr;
      len_q  <= cmd_len;
      wd_q   <= data_q;
    end
  end

  assign b_req     = req_q;
  assign b_we      = we_q;
  assign b_addr    = addr_q;
  assign b_len     = len_q;
  assign b_wdata   = wd_q;
  assign busy      = req_q;
  assign rsp_valid = req_q & b_ack;
  assign rsp_rd    = ~we_q;

  assert_req_after_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> b_req);
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && !b_ack) |=> (b_req && $stable(b_addr) && $stable(b_we) &&
                           $stable(b_len) && $stable(b_wdata)));
  assert_drop_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && b_ack) |=> !b_req);
endmodule

// File: rtl/cmdb_regs.sv
module cmdb_regs
  import cmdb_pkg::*;
#(
  parameter int DW        = 64,
  parameter int BUS_DW    = 32,
  parameter int DONE_BIT  = 11,
  parameter int RDATA_LSB = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              data_wr,
  input  logic [BUS_DW-1:0] wdata_hi,
  input  logic              stat_rd,
  input  logic              rd_acc,
  input  logic              rsp_valid,
  input  logic              rsp_rd,
  input  logic              rsp_err,
  input  logic [BUS_DW-1:0] rsp_data,
  output logic [BUS_DW-1:0] data_q,
  output logic [DW-1:0]     h_rdata
);
  localparam int PAD_W = DW - BUS_DW;

  logic [DW-1:0] stat_q, stat_d, done_word, rd_d, rd_q;

  always_comb begin
    done_word = '0;
    done_word[DONE_BIT] = 1'b1;
    if (rsp_rd) done_word[RDATA_LSB +: BUS_DW] = rsp_err ? '1 : rsp_data;
  end

  always_comb begin
    stat_d = stat_q;
    if (rsp_valid)    stat_d = done_word;
    else if (stat_rd) stat_d = '0;
  end

  always_comb begin
    rd_d = '0;
    if (rd_acc) begin
      case (sel)
        SEL_STAT: rd_d = stat_q;
        SEL_DATA: rd_d = {data_q, {PAD_W{1'b0}}};
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= wdata_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rd_q   <= '0;
    end else begin
      stat_q <= stat_d;
      rd_q   <= rd_d;
    end
  end

  assign h_rdata = rd_q;

  assert_done_on_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> stat_q[DONE_BIT]);
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rsp_valid) |=> (stat_q == '0));
  assert_stat_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && !stat_rd) |=> $stable(stat_q));
endmodule

// File: rtl/cmdb_top.sv
module cmdb_top
  import cmdb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUS_AW    = 32,
  parameter int BUS_DW    = 32,
  parameter int LEN_W     = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic              h_re,
  input  logic              h_full,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [63:0]       h_wdata,
  output logic [63:0]       h_rdata,
  output logic              busy,
  output logic              b_req,
  output logic              b_we,
  output logic [BUS_AW-1:0] b_addr,
  output logic [LEN_W-1:0]  b_len,
  output logic [BUS_DW-1:0] b_wdata,
  input  logic              b_ack,
  input  logic [BUS_DW-1:0] b_rdata,
  input  logic              b_err
);
  localparam int DW = 64;

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  reg_sel_e          sel;
  logic              data_wr, stat_rd, rd_acc, cmd_go, cmd_rd;
  logic [BUS_AW-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic [BUS_DW-1:0] data_q;
  logic              rsp_valid, rsp_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  cmdb_decode #(
    .ADDR_W(ADDR_W), .DW(DW), .BUS_AW(BUS_AW), .LEN_W(LEN_W),
    .MAX_BYTES(MAX_BYTES), .RD_BIT(48), .LEN_LSB(56)
  ) u_dec (
    .clk(clk), .rst_n(core_rst_n), .h_we(h_we), .h_re(h_re), .h_full(h_full),
    .h_addr(h_addr), .h_wdata(h_wdata), .busy(busy), .sel(sel),
    .data_wr(data_wr), .stat_rd(stat_rd), .rd_acc(rd_acc), .cmd_go(cmd_go),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_len(cmd_len)
  );

  cmdb_master #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .LEN_W(LEN_W)) u_mst (
    .clk(clk), .rst_n(core_rst_n), .cmd_go(cmd_go), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .data_q(data_q), .b_ack(b_ack),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_len(b_len),
    .b_wdata(b_wdata), .busy(busy), .rsp_valid(rsp_valid), .rsp_rd(rsp_rd)
  );

  cmdb_regs #(.DW(DW), .BUS_DW(BUS_DW), .DONE_BIT(11), .RDATA_LSB(26)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .sel(sel), .data_wr(data_wr),
    .wdata_hi(h_wdata[DW-1:DW-BUS_DW]), .stat_rd(stat_rd), .rd_acc(rd_acc),
    .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_err(b_err),
    .rsp_data(b_rdata), .data_q(data_q), .h_rdata(h_rdata)
  );
endmodule

// File: tb/cmdb_top_test.sv
module cmdb_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_we = 1'b0, h_re = 1'b0, h_full = 1'b1;
  logic [7:0]  h_addr = '0;
  logic [63:0] h_wdata = '0;
  logic [63:0] h_rdata;
  logic        busy, b_req, b_we;
  logic [31:0] b_addr, b_wdata;
  logic [3:0]  b_len;
  logic        b_ack = 1'b0, b_err = 1'b0;
  logic [31:0] b_rdata = '0;

  int total = 0, bad = 0, cyc = 0, pcnt = 0;
  logic [31:0] last_wd = '0;

  always #4 clk = ~clk;

  cmdb_top uut (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_re(h_re), .h_full(h_full),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .busy(busy),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_len(b_len),
    .b_wdata(b_wdata), .b_ack(b_ack), .b_rdata(b_rdata), .b_err(b_err)
  );

  function automatic logic [31:0] pdata(logic [31:0] a);
    return a ^ 32'h5A5A_1234;
  endfunction
  function automatic logic [63:0] mk(bit rd, int len, logic [31:0] a);
    logic [63:0] w = '0;
    w[59:56] = 4'(len); w[48] = rd; w[31:0] = a;
    return w;
  endfunction
  function automatic logic [63:0] st_rd(logic [31:0] d);
    return (64'(d) << 26) | 64'h800;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral: latency = addr[1:0]+1, error for addresses 0xF.......
  always @(negedge clk) begin
    if (b_ack) begin
      b_ack <= 1'b0; pcnt = 0;
    end else if (b_req) begin
      pcnt++;
      if (pcnt == int'(b_addr[1:0]) + 1) begin
        b_ack   <= 1'b1;
        b_err   <= (b_addr[31:28] == 4'hF);
        b_rdata <= (b_addr[31:28] == 4'hF) ? 32'h0BAD_0BAD : pdata(b_addr);
        if (b_we) last_wd <= b_wdata;
      end
    end
  end

  // behavioural reference model
  logic        m_busy = 0, m_rd = 0;
  logic [31:0] m_addr = 0, m_wd = 0, m_dreg = 0;
  logic [3:0]  m_len = 0;
  logic [63:0] m_st = 0, m_rdx = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_st <= 0; m_dreg <= 0; m_rdx <= 0;
    end else begin
      logic rsp;
      logic [1:0] s;
      s = h_addr[4:3];
      rsp = m_busy && b_ack;
      m_rdx <= 0;
      if (h_re && h_full) m_rdx <= (s == 2) ? m_st : (s == 3) ? {m_dreg, 32'h0} : 64'h0;
      if (rsp) begin
        m_busy <= 0;
        m_st <= !m_rd ? 64'h800 : st_rd(b_err ? 32'hFFFF_FFFF : b_rdata);
      end else if (h_re && h_full && s == 2) m_st <= 0;
      if (h_we && h_full && s == 3) m_dreg <= h_wdata[63:32];
      if (h_we && h_full && s == 0 && !m_busy && h_wdata[59:56] <= 8) begin
        m_busy <= 1; m_rd <= h_wdata[48]; m_addr <= h_wdata[31:0];
        m_len <= h_wdata[59:56]; m_wd <= m_dreg;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 busy", 64'(busy), 64'(m_busy));
      check("R10 b_req", 64'(b_req), 64'(m_busy));
      check("R7 h_rdata", h_rdata, m_rdx);
      if (m_busy) begin
        check("R2 b_addr", 64'(b_addr), 64'(m_addr));
        check("R2 b_len", 64'(b_len), 64'(m_len));
        check("R2 b_we", 64'(b_we), 64'(!m_rd));
        if (!m_rd) check("R6 b_wdata", 64'(b_wdata), 64'(m_wd));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hw(logic [1:0] s, logic [63:0] v, bit full = 1);
    @(negedge clk);
    h_addr = {3'b101, s, 3'b011}; h_wdata = v; h_full = full; h_we = 1;
    @(negedge clk);
    h_we = 0; h_full = 1;
  endtask
  task automatic hr(logic [1:0] s, logic [63:0] exp, string tag, bit full = 1);
    @(negedge clk);
    h_addr = {3'b010, s, 3'b100}; h_full = full; h_re = 1;
    @(negedge clk);
    h_re = 0; h_full = 1;
    check(tag, h_rdata, exp);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 50; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R10 reset busy", 64'(busy), 0);
    hr(2, 0, "R7 reset status");
    // R8 data register
    hw(3, 64'h1122_3344_FFFF_FFFF);
    hr(3, 64'h1122_3344_0000_0000, "R8 data readback");
    // R9 zero-reading registers
    hr(0, 0, "R9 control reads zero");
    hr(1, 0, "R9 reset reads zero");
    // R6 write command
    hw(0, mk(0, 4, 32'h0000_0100));
    check("R2 write request", {b_req, b_we, b_len, b_addr}, {1'b1, 1'b1, 4'd4, 32'h100});
    wait_idle();
    check("R6 write data on bus", 64'(last_wd), 64'h1122_3344);
    hr(2, 64'h800, "R6 write status");
    hr(2, 0, "R7 cleared after read");
    // R4 read command
    hw(0, mk(1, 4, 32'h0000_0203));
    wait_idle();
    hr(2, st_rd(pdata(32'h203)), "R4 read status");
    // R5 read error
    hw(0, mk(1, 4, 32'hF000_0010));
    wait_idle();
    hr(2, st_rd(32'hFFFF_FFFF), "R5 error status");
    // R6 write with bus error
    hw(0, mk(0, 2, 32'hF000_0021));
    wait_idle();
    hr(2, 64'h800, "R6 write error status");
    // R3 oversized counts
    hw(0, mk(1, 2, 32'h0000_0010));
    wait_idle();
    hw(0, mk(1, 9, 32'h0000_0020));
    check("R3 len 9 no request", 64'(b_req), 0);
    hw(0, mk(1, 15, 32'h0000_0030));
    check("R3 len 15 no request", 64'(b_req), 0);
    hr(2, st_rd(pdata(32'h10)), "R3 status unchanged");
    // boundary counts 8 and 0 accepted
    hw(0, mk(1, 8, 32'h0000_0041));
    check("R3 len 8 accepted", 64'(b_req), 1);
    wait_idle();
    hw(0, mk(1, 0, 32'h0000_0050));
    check("R3 len 0 accepted", 64'(b_req), 1);
    wait_idle();
    hr(2, st_rd(pdata(32'h50)), "R4 len 0 status");
    // R10 command during busy ignored
    hw(0, mk(1, 4, 32'h0000_0303));
    hw(0, mk(0, 4, 32'h0000_0400));
    check("R10 addr held", 64'(b_addr), 64'h303);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R10 no second request", 64'(b_req), 0);
    hr(2, st_rd(pdata(32'h303)), "R10 first command result");
    // R1 partial accesses ignored
    hw(3, 64'hDEAD_BEEF_0000_0000, 0);
    hr(3, 64'h1122_3344_0000_0000, "R1 partial write ignored");
    hw(0, mk(0, 1, 32'h0000_0060), 0);
    check("R1 partial control ignored", 64'(b_req), 0);
    hw(0, mk(0, 1, 32'h0000_0060));
    wait_idle();
    hr(2, 0, "R1 partial read returns zero", 0);
    // R9 writes to status/reset have no effect
    hw(2, 64'hFFFF_FFFF_FFFF_FFFF);
    hw(1, 64'hFFFF_FFFF_FFFF_FFFF);
    hr(2, 64'h800, "R9 status survives writes");
    hr(3, 64'h1122_3344_0000_0000, "R9 data survives writes");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule